// File: doc/BRIEF.md
# Dual-Digit Multiplexed Hex Display Controller

This block lights two common-anode seven-segment digits from two independent 4-bit values while owning only one seven-line segment bus and two digit-power enables. A free-running divider turns the system clock into a periodic toggle tick. A two-state machine swaps the powered digit on every tick, and the segment bus always carries the glyph of the value that belongs to the powered digit. With the default 48 MHz clock and a 1000 Hz tick, each digit is refreshed at 500 Hz, far above the rate at which the eye sees flicker.

A single hex decoder serves both digits. Its input is steered by the machine's next state, and the anode enables and the segment pattern are registered together so they change on the same edge. The block also presents the unsigned 5-bit sum of the two values, carry included, for a bank of indicator LEDs.

The machine has two states. SHOW_LEFT powers the left digit and SHOW_RIGHT powers the right digit. The transition SHOW_LEFT to SHOW_RIGHT and the transition SHOW_RIGHT to SHOW_LEFT both fire on the toggle tick, and each state holds itself when no tick occurs. Reset forces SHOW_LEFT.

Top module: `dual_digit_mux`

## Requirements
- R1: Each 4-bit value is shown as a hex glyph; in active-high form with bit 0 = segment a through bit 6 = segment g, values 0..F give 3F,06,5B,4F,66,6D,7D,07,7F,6F,77,7C,39,5E,79,71.
- R2: Segment lines are active-low (seg_n = inverse of the R1 pattern); digit enables are active-low with dig_en_n[1] powering the left digit and dig_en_n[0] the right.
- R3: The toggle tick is high for one cycle in every CLK_HZ/TICK_HZ clock cycles, counted from the edge that follows reset release.
- R4: After the first clock edge out of reset, exactly one digit enable is low in every cycle.
- R5: The state moves SHOW_LEFT to SHOW_RIGHT or SHOW_RIGHT to SHOW_LEFT on each tick edge and holds on every other edge; the first state after reset is SHOW_LEFT.
- R6: The segment bus and the digit enables are registered on the same edge; the segments show the glyph of the input value, as sampled at that edge, that belongs to the digit being powered.
- R7: sum_out equals left value plus right value as an unsigned 5-bit number, with no register delay.
- R8: While reset is high, at the next edge the divider clears, the state becomes SHOW_LEFT, both enables go high (off) and all segment lines go high (dark).
- R9: The pairs 0/0, 0/6, C/9 and F/3 show the correct glyph on each digit through full left/right alternations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| left_val | input | 4 | Value shown on the left digit |
| right_val | input | 4 | Value shown on the right digit |
| seg_n | output | 7 | Shared segment lines, active-low, bit 0 = a |
| dig_en_n | output | 2 | Digit enables, active-low, [1] left, [0] right |
| sum_out | output | 5 | Unsigned sum of the two values |

## Verification
The bench runs the divider at a small ratio and tracks an independent model of tick timing and state, so a divider that counts one cycle too many or too few, or a machine that flips on a wrong edge, makes the enables disagree with the model at the first tick. Values change while a digit is powered, which exposes a design that decodes the current state instead of the next state and so shows the other digit's glyph for one cycle after each swap. Sums at 15+15 and 0+0 catch a dropped carry, and a mid-run reset catches enables or segments that are left lit during reset.

// File: rtl/dual_digit_pkg.sv
package dual_digit_pkg;

    typedef enum logic {
        SHOW_LEFT  = 1'b0,
        SHOW_RIGHT = 1'b1
    } digit_state_e;

    localparam int SEG_W = 7;

    // Active-high glyph, bit 0 = segment a ... bit 6 = segment g
    function automatic logic [SEG_W-1:0] hex_glyph(input logic [3:0] v);
        logic [SEG_W-1:0] g;
        unique case (v)
            4'h0: g = 7'h3F;
            4'h1: g = 7'h06;
            4'h2: g = 7'h5B;
            4'h3: g = 7'h4F;
            4'h4: g = 7'h66;
            4'h5: g = 7'h6D;
            4'h6: g = 7'h7D;
            4'h7: g = 7'h07;
            4'h8: g = 7'h7F;
            4'h9: g = 7'h6F;
            4'hA: g = 7'h77;
            4'hB: g = 7'h7C;
            4'hC: g = 7'h39;
            4'hD: g = 7'h5E;
            4'hE: g = 7'h79;
            default: g = 7'h71;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/tick_divider.sv
module tick_divider #(
    parameter int DIV = 48000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/hex_seg_decoder.sv
module hex_seg_decoder
    import dual_digit_pkg::*;
(
    input  logic [3:0]       value,
    output logic [SEG_W-1:0] glyph
);
    always_comb begin
        glyph = hex_glyph(value);
    end
endmodule

// File: rtl/digit_fsm.sv
module digit_fsm
    import dual_digit_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [SEG_W-1:0] glyph,
    output digit_state_e     state_next,
    output logic [SEG_W-1:0] seg_n,
    output logic [1:0]       dig_en_n
);
    digit_state_e state_q;

    always_comb begin
        state_next = state_q;
        unique case (state_q)
            SHOW_LEFT:  if (tick) state_next = SHOW_RIGHT;
            SHOW_RIGHT: if (tick) state_next = SHOW_LEFT;
            default:    state_next = SHOW_LEFT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SHOW_LEFT;
        end else begin
            state_q <= state_next;
        end
    end

    // Enables and segments follow the next state on the same edge
    always_ff @(posedge clk) begin
        if (rst) begin
            seg_n    <= '1;
            dig_en_n <= 2'b11;
        end else begin
            seg_n <= ~glyph;
            unique case (state_next)
                SHOW_LEFT:  dig_en_n <= 2'b01;
                SHOW_RIGHT: dig_en_n <= 2'b10;
                default:    dig_en_n <= 2'b11;
            endcase
        end
    end
endmodule

// File: rtl/dual_digit_mux.sv
module dual_digit_mux
    import dual_digit_pkg::*;
#(
    parameter int CLK_HZ  = 48_000_000,
    parameter int TICK_HZ = 1000,
    parameter int VAL_W   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [VAL_W-1:0] left_val,
    input  logic [VAL_W-1:0] right_val,
    output logic [6:0]       seg_n,
    output logic [1:0]       dig_en_n,
    output logic [VAL_W:0]   sum_out
);
    localparam int DIV = CLK_HZ / TICK_HZ;

    logic             tick;
    digit_state_e     sel_next;
    logic [VAL_W-1:0] shown_val;
    logic [SEG_W-1:0] glyph;

    tick_divider #(.DIV(DIV)) u_div (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    assign shown_val = (sel_next == SHOW_RIGHT) ? right_val : left_val;

    hex_seg_decoder u_dec (
        .value (shown_val[3:0]),
        .glyph (glyph)
    );

    digit_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .glyph      (glyph),
        .state_next (sel_next),
        .seg_n      (seg_n),
        .dig_en_n   (dig_en_n)
    );

    assign sum_out = {1'b0, left_val} + {1'b0, right_val};
endmodule

// File: rtl/dual_digit_mux_chk.sv
module dual_digit_mux_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic [6:0] seg_n,
    input logic [1:0] dig_en_n
);
    p_one_digit_r4: assert property (@(posedge clk) disable iff (rst)
        $countones(~dig_en_n) <= 1);

    p_flip_on_tick_r5: assert property (@(posedge clk) disable iff (rst)
        (tick && dig_en_n != 2'b11) |=> (dig_en_n == ~$past(dig_en_n)));

    p_hold_no_tick_r5: assert property (@(posedge clk) disable iff (rst)
        (!tick && dig_en_n != 2'b11) |=> $stable(dig_en_n));

    p_lit_when_powered_r6: assert property (@(posedge clk) disable iff (rst)
        (dig_en_n != 2'b11) |-> (seg_n != 7'h7F));

    p_reset_dark_r8: assert property (@(posedge clk)
        rst |=> (dig_en_n == 2'b11 && seg_n == 7'h7F));
endmodule

bind dual_digit_mux dual_digit_mux_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .seg_n    (seg_n),
    .dig_en_n (dig_en_n)
);

// File: tb/tb_dual_digit_mux.sv
module tb_dual_digit_mux;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 8;
    localparam int TICK_HZ    = 1;
    localparam int DIV        = CLK_HZ / TICK_HZ;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] left_val = '0;
    logic [3:0] right_val = '0;
    logic [6:0] seg_n;
    logic [1:0] dig_en_n;
    logic [4:0] sum_out;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_digit_mux #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .VAL_W(4)) dut (
        .clk(clk), .rst(rst), .left_val(left_val), .right_val(right_val),
        .seg_n(seg_n), .dig_en_n(dig_en_n), .sum_out(sum_out)
    );

    function automatic logic [6:0] ref_glyph(input logic [3:0] v);
        case (v)
            4'h0: return 7'h3F;  4'h1: return 7'h06;
            4'h2: return 7'h5B;  4'h3: return 7'h4F;
            4'h4: return 7'h66;  4'h5: return 7'h6D;
            4'h6: return 7'h7D;  4'h7: return 7'h07;
            4'h8: return 7'h7F;  4'h9: return 7'h6F;
            4'hA: return 7'h77;  4'hB: return 7'h7C;
            4'hC: return 7'h39;  4'hD: return 7'h5E;
            4'hE: return 7'h79;  default: return 7'h71;
        endcase
    endfunction

    // Reference timing model built from R3, R5, R8
    int         m_cnt = 0;
    logic       m_right = 1'b0;
    logic       m_valid = 1'b0;
    logic [3:0] m_l = '0;
    logic [3:0] m_r = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt   <= 0;
            m_right <= 1'b0;
            m_valid <= 1'b0;
        end else begin
            m_valid <= 1'b1;
            if (m_cnt == DIV - 1) begin
                m_cnt   <= 0;
                m_right <= ~m_right;
            end else begin
                m_cnt <= m_cnt + 1;
            end
        end
        m_l <= left_val;
        m_r <= right_val;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_display();
        logic [1:0] e_en;
        logic [6:0] e_seg;
        if (!m_valid) begin
            e_en  = 2'b11;
            e_seg = 7'h7F;
            check("R8 enables", {30'd0, dig_en_n}, {30'd0, e_en});
            check("R8 segments", {25'd0, seg_n}, {25'd0, e_seg});
        end else begin
            e_en  = m_right ? 2'b10 : 2'b01;
            e_seg = ~ref_glyph(m_right ? m_r : m_l);
            check("R2 R4 R5 enables", {30'd0, dig_en_n}, {30'd0, e_en});
            check("R1 R6 segments", {25'd0, seg_n}, {25'd0, e_seg});
        end
    endtask

    task automatic check_sum();
        #1;
        check("R7 sum", {27'd0, sum_out}, {28'd0, left_val} + {28'd0, right_val});
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (2) @(negedge clk);
        check_display();  // R8 reset state
        @(negedge clk);
        rst = 1'b0;

        // R9 directed pairs, each held for two full alternations
        for (int p = 0; p < 4; p++) begin
            case (p)
                0: begin left_val = 4'h0; right_val = 4'h0; end
                1: begin left_val = 4'h0; right_val = 4'h6; end
                2: begin left_val = 4'hC; right_val = 4'h9; end
                default: begin left_val = 4'hF; right_val = 4'h3; end
            endcase
            check_sum();
            for (int c = 0; c < 4 * DIV; c++) begin
                @(negedge clk);
                check_display();  // R9
            end
        end

        // R7 carry corner
        left_val = 4'hF; right_val = 4'hF;
        check_sum();

        // Random values changing mid-digit (R1, R6)
        for (int c = 0; c < 600; c++) begin
            @(negedge clk);
            check_display();
            if ($urandom_range(0, 2) == 0) begin
                left_val  = 4'($urandom_range(0, 15));
                right_val = 4'($urandom_range(0, 15));
                check_sum();
            end
            if (c == 300) rst = 1'b1;   // R8 mid-run reset
            if (c == 303) rst = 1'b0;
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule